// File: doc/BRIEF.md
# Power-Management Register Target

This block is the register side of an I2C target in a power-management companion chip. A bus controller in front of it handles the bit-level signalling and passes it three kinds of byte event: the start of a write transaction, a received data byte, and a request for one read byte. The block keeps an 8-bit register pointer. The first byte of a write transaction loads the pointer. Each later byte, and each read, uses the pointed address and then advances the pointer.

The simple configuration registers are held inside the block. Each one has its own write rule: some stored fields are clamped, some are masked, one register always takes a constant value, and one address resets the whole device. The interrupt and real-time-clock address windows belong to sibling blocks. Accesses to those windows are passed on over a registered local strobe bus, and read data from that bus is returned on the same cycle as the read strobe.

A small state machine sequences each transaction. It has four states. ST_IDLE means no transaction is open. ST_PTR means a write transaction has started and the next byte is the pointer. ST_WDATA means later bytes are register writes. ST_RSP is the single cycle in which read data is presented.

The state changes are as follows:
- A start event moves any state to ST_PTR.
- A byte received in ST_PTR moves to ST_WDATA.
- A byte received in ST_WDATA stays in ST_WDATA.
- A read request with no other event moves any state to ST_RSP.
- ST_RSP with no new read request returns to ST_IDLE.
- A byte received in ST_IDLE or ST_RSP is ignored, and the state goes to ST_IDLE.

When several events arrive in the same cycle, start has priority over byte, and byte has priority over read.

Top module: `pmic_regslave`

## Requirements
- R1: After a start-of-write event, the next received byte loads the pointer and writes nothing. A byte received outside a write transaction (in ST_IDLE or after a read) is ignored, and the pointer does not change.
- R2: Each later byte of a write transaction is written to the pointed address, and the pointer then increments. The pointer wraps from 0xFF to 0x00.
- R3: A read request returns the pointed register on bus_rdata, with bus_rd_valid high exactly one cycle after the request, and the pointer increments. Requests held on consecutive cycles give one response per cycle.
- R4: Address 0x01 always reads 0x22, and writes to it are ignored.
- R5: Core-voltage clamps:
  - A write of v to 0x02 stores (v & 0x0E) | min(v & 0x1F, 0x12).
  - A write of v to 0x04 or 0x05 stores min(v & 0x1F, 0x12).
- R6: Stored-bit masks:
  - 0x03, 0x0A, 0x12, 0x13, 0x32, 0x34 and 0x37 keep all 8 bits.
  - 0x06 and 0x0C–0x11 keep bits 1:0.
  - 0x07 keeps bits 5:0.
  - 0x08 and 0x09 keep bits 2:0.
  - 0x0B, 0x16 and 0x36 keep bits 6:0.
  - 0x33 and 0x35 keep bits 4:0.
  - 0x38 keeps bits 3:0.
  - 0x3A (debounce) keeps bits 5:0.
- R7: A byte with bit 0 set written to 0x14 restores every held register to its reset value, sets the pointer to 0x00 (this wins over the increment), and pulses dev_off_pulse for one cycle after that byte. A byte with bit 0 clear has no effect. 0x14 always reads 0x00.
- R8: The oscillator register 0x15 keeps bits 2:0. Reads return the stored value with bit 7 set (32 kHz clock good).
- R9: Any write to 0x20 stores 0x0D, whatever the byte.
- R10: Reset values are:
  - 0x02=0x0C, 0x03=0x05, 0x04=0x02, 0x05=0x0C, 0x06=0x03
  - 0x07=0x33, 0x08=0x03, 0x0A=0x95, 0x0B=0x7E, 0x0E=0x03
  - 0x15=0x01 (read 0x81), 0x16=0x09
  - 0x36=0x03, 0x37=0xC0, 0x3A=0x05
  - all other held registers 0x00
  
  Address 0x39 reads 0x00.
- R11: Writes to 0x17–0x1C and 0x21–0x31 appear one cycle after the byte as a one-cycle fwd_wr, with fwd_addr and fwd_wdata. Reads of those addresses raise fwd_rd with fwd_addr in the response cycle, and fwd_rdata is returned as bus_rdata.
- R12: Every other address reads 0x00, and writes to it are ignored. The pointer still increments on such accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start_wr | input | 1 | Start-of-write-transaction event |
| bus_wr_byte | input | 1 | A data byte was received |
| bus_wdata | input | 8 | Received byte |
| bus_rd_req | input | 1 | Request for one read byte |
| bus_rd_valid | output | 1 | Read data is valid this cycle |
| bus_rdata | output | 8 | Read data |
| fwd_wr | output | 1 | Write strobe to sibling blocks |
| fwd_rd | output | 1 | Read strobe to sibling blocks |
| fwd_addr | output | 8 | Sibling register address |
| fwd_wdata | output | 8 | Sibling write data |
| fwd_rdata | input | 8 | Sibling read data, valid while fwd_rd is high |
| dev_off_pulse | output | 1 | One-cycle device reset request to siblings |

## Verification
The case that needs the most care is the device-off write landing in the same cycle as the pointer auto-increment. The bench provokes it with write bursts that cross 0x14 carrying bit 0 set, in both directed and random form. It judges the result by whether the following bytes land at 0x00 and 0x01, and by reading back reset defaults. A second overlap occurs in read bursts: a sibling read answer and the acceptance of the next read request fall in the same cycle. The bench holds bus_rd_req high across forwarded and local addresses and compares every byte against its model.

// File: rtl/pmic_regs_pkg.sv
package pmic_regs_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_CFG   = 29;
    localparam int CFG_IDX_W = $clog2(NUM_CFG);

    localparam logic [7:0] ADR_REV  = 8'h01;
    localparam logic [7:0] ADR_OFF  = 8'h14;
    localparam logic [7:0] ADR_OSC  = 8'h15;
    localparam logic [7:0] ADR_BB   = 8'h20;
    localparam logic [7:0] ADR_PIN  = 8'h39;
    localparam logic [7:0] ADR_VC1  = 8'h02;
    localparam logic [7:0] ADR_VC3  = 8'h04;
    localparam logic [7:0] ADR_VC4  = 8'h05;
    localparam logic [7:0] ADR_DEB  = 8'h3A;

    localparam logic [7:0] REV_CODE = 8'h22;
    localparam logic [7:0] BB_CONST = 8'h0D;
    localparam logic [7:0] VC_CEIL  = 8'h12;
    localparam logic [7:0] CLK_GOOD = 8'h80;

    typedef enum logic [1:0] {AK_NONE, AK_CONST, AK_CFG, AK_FWD} addr_kind_e;

    // Which owner answers an address.
    function automatic addr_kind_e kind_of(input logic [7:0] a);
        if (a == ADR_REV || a == ADR_OFF || a == ADR_PIN)
            return AK_CONST;
        if ((a >= 8'h02 && a <= 8'h13) || a == 8'h15 || a == 8'h16 ||
            a == ADR_BB || (a >= 8'h32 && a <= 8'h38) || a == ADR_DEB)
            return AK_CFG;
        if ((a >= 8'h17 && a <= 8'h1C) || (a >= 8'h21 && a <= 8'h31))
            return AK_FWD;
        return AK_NONE;
    endfunction

    // Storage slot of a held register (meaningful for AK_CFG only).
    function automatic logic [CFG_IDX_W-1:0] slot_of(input logic [7:0] a);
        logic [7:0] s;
        if (a <= 8'h13)      s = a - 8'h02;
        else if (a == 8'h15) s = 8'd18;
        else if (a == 8'h16) s = 8'd19;
        else if (a == ADR_BB) s = 8'd20;
        else if (a <= 8'h38) s = a - 8'h32 + 8'd21;
        else                 s = 8'd28;
        return s[CFG_IDX_W-1:0];
    endfunction

    // Inverse of slot_of, used to build the bank.
    function automatic logic [7:0] addr_of_slot(input int s);
        if (s < 18)  return 8'(s + 2);
        if (s == 18) return 8'h15;
        if (s == 19) return 8'h16;
        if (s == 20) return ADR_BB;
        if (s < 28)  return 8'(s - 21 + 'h32);
        return ADR_DEB;
    endfunction

    function automatic logic [7:0] rst_val(input logic [7:0] a);
        case (a)
            8'h02: return 8'h0C;
            8'h03: return 8'h05;
            8'h04: return 8'h02;
            8'h05: return 8'h0C;
            8'h06: return 8'h03;
            8'h07: return 8'h33;
            8'h08: return 8'h03;
            8'h0A: return 8'h95;
            8'h0B: return 8'h7E;
            8'h0E: return 8'h03;
            8'h15: return 8'h01;
            8'h16: return 8'h09;
            8'h36: return 8'h03;
            8'h37: return 8'hC0;
            8'h3A: return 8'h05;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] clamp_vc(input logic [7:0] v);
        logic [7:0] t;
        t = v & 8'h1F;
        return (t > VC_CEIL) ? VC_CEIL : t;
    endfunction

    // Value actually stored when byte v is written to held register a.
    function automatic logic [7:0] wr_shape(input logic [7:0] a, input logic [7:0] v);
        case (a)
            8'h02:                      return (v & 8'h0E) | clamp_vc(v);
            8'h04, 8'h05:               return clamp_vc(v);
            8'h06, 8'h0C, 8'h0D, 8'h0E,
            8'h0F, 8'h10, 8'h11:        return v & 8'h03;
            8'h07, 8'h3A:               return v & 8'h3F;
            8'h08, 8'h09, 8'h15:        return v & 8'h07;
            8'h0B, 8'h16, 8'h36:        return v & 8'h7F;
            8'h20:                      return BB_CONST;
            8'h33, 8'h35:               return v & 8'h1F;
            8'h38:                      return v & 8'h0F;
            default:                    return v;
        endcase
    endfunction

    function automatic logic [7:0] rd_view(input logic [7:0] a, input logic [7:0] v);
        return (a == ADR_OSC) ? (v | CLK_GOOD) : v;
    endfunction

    function automatic logic [7:0] const_val(input logic [7:0] a);
        return (a == ADR_REV) ? REV_CODE : 8'h00;
    endfunction

endpackage

// File: rtl/pmic_txn_fsm.sv
module pmic_txn_fsm
    import pmic_regs_pkg::*;
#(
    parameter int AW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_start,
    input  logic          ev_byte,
    input  logic          ev_rd,
    input  logic [AW-1:0] byte_in,
    input  logic          soft_clr,
    output logic [AW-1:0] ptr,
    output logic          wr_fire,
    output logic          rd_fire,
    output logic          rsp_active
);

    typedef enum logic [1:0] {ST_IDLE, ST_PTR, ST_WDATA, ST_RSP} txn_state_e;

    txn_state_e    state_q, state_d;
    logic [AW-1:0] ptr_q;
    logic          ptr_load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ev_start)     state_d = ST_PTR;
                else if (ev_byte) state_d = ST_IDLE;
                else if (ev_rd)   state_d = ST_RSP;
            end
            ST_PTR: begin
                if (ev_start)     state_d = ST_PTR;
                else if (ev_byte) state_d = ST_WDATA;
                else if (ev_rd)   state_d = ST_RSP;
            end
            ST_WDATA: begin
                if (ev_start)     state_d = ST_PTR;
                else if (ev_byte) state_d = ST_WDATA;
                else if (ev_rd)   state_d = ST_RSP;
            end
            ST_RSP: begin
                if (ev_start)     state_d = ST_PTR;
                else if (ev_byte) state_d = ST_IDLE;
                else if (ev_rd)   state_d = ST_RSP;
                else              state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ptr_load   = (state_q == ST_PTR)   && ev_byte && !ev_start;
        wr_fire    = (state_q == ST_WDATA) && ev_byte && !ev_start;
        rd_fire    = ev_rd && !ev_start && !ev_byte;
        rsp_active = (state_q == ST_RSP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 ptr_q <= '0;
        else if (soft_clr)          ptr_q <= '0;
        else if (ptr_load)          ptr_q <= byte_in;
        else if (wr_fire || rd_fire) ptr_q <= ptr_q + 1'b1;
    end

    assign ptr = ptr_q;

    // R1: the pointer byte lands in the pointer
    a_r1_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load |=> ptr_q == $past(byte_in));

    // R2: a data byte advances the pointer (with wrap)
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && !soft_clr) |=> ptr_q == AW'($past(ptr_q) + 1'b1));

    // R3: a read is answered in the next cycle
    a_r3_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> rsp_active);

    // R7: device-off wins over the increment
    a_r7_ptr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> ptr_q == '0);

endmodule

// File: rtl/pmic_cfg_bank.sv
module pmic_cfg_bank
    import pmic_regs_pkg::*;
#(
    parameter int DW  = BYTE_W,
    parameter int NUM = NUM_CFG,
    parameter int IW  = CFG_IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_clr,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_slot,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] cfg_q [NUM]
);

    localparam int S_BB  = int'(slot_of(ADR_BB));
    localparam int S_VC3 = int'(slot_of(ADR_VC3));
    localparam int S_VC4 = int'(slot_of(ADR_VC4));
    localparam int S_DEB = int'(slot_of(ADR_DEB));

    for (genvar g = 0; g < NUM; g++) begin : g_reg
        localparam logic [7:0] SLOT_ADR = addr_of_slot(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cfg_q[g] <= rst_val(SLOT_ADR);
            else if (soft_clr)
                cfg_q[g] <= rst_val(SLOT_ADR);
            else if (wr_en && wr_slot == IW'(g))
                cfg_q[g] <= wr_shape(SLOT_ADR, wr_data);
        end
    end

    // R9: battery-backup register only ever holds 0x00 or 0x0D
    a_r9_bb_const: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[S_BB] == 8'h00) || (cfg_q[S_BB] == BB_CONST));

    // R5: clamped core-voltage registers never exceed the ceiling
    a_r5_vc_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[S_VC3] <= VC_CEIL) && (cfg_q[S_VC4] <= VC_CEIL));

    // R6: debounce keeps six bits
    a_r6_deb_width: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[S_DEB][7:6] == 2'b00);

endmodule

// File: rtl/pmic_resp_path.sv
module pmic_resp_path
    import pmic_regs_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int AW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_fire,
    input  logic          rd_fire,
    input  logic          target_fwd,
    input  logic [AW-1:0] ptr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] local_rdata,
    input  logic [DW-1:0] fwd_rdata,
    input  logic          rsp_active,
    output logic          fwd_wr,
    output logic          fwd_rd,
    output logic [AW-1:0] fwd_addr,
    output logic [DW-1:0] fwd_wdata,
    output logic [DW-1:0] rsp_data
);

    logic          fwd_wr_q, fwd_rd_q, from_fwd_q;
    logic [AW-1:0] fwd_addr_q;
    logic [DW-1:0] fwd_wdata_q, hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_wr_q    <= 1'b0;
            fwd_rd_q    <= 1'b0;
            from_fwd_q  <= 1'b0;
            fwd_addr_q  <= '0;
            fwd_wdata_q <= '0;
            hold_q      <= '0;
        end else begin
            fwd_wr_q <= wr_fire && target_fwd;
            fwd_rd_q <= rd_fire && target_fwd;
            if (wr_fire || rd_fire) fwd_addr_q <= ptr;
            if (wr_fire)            fwd_wdata_q <= wdata;
            if (rd_fire) begin
                hold_q     <= local_rdata;
                from_fwd_q <= target_fwd;
            end
        end
    end

    always_comb begin
        rsp_data = '0;
        if (rsp_active) rsp_data = from_fwd_q ? fwd_rdata : hold_q;
    end

    assign fwd_wr    = fwd_wr_q;
    assign fwd_rd    = fwd_rd_q;
    assign fwd_addr  = fwd_addr_q;
    assign fwd_wdata = fwd_wdata_q;

    // R11: the two sibling strobes never overlap
    a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_wr_q && fwd_rd_q));

    // R11: a sibling read only happens in a response cycle
    a_r11_rd_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_rd_q |-> rsp_active);

endmodule

// File: rtl/pmic_regslave.sv
module pmic_regslave
    import pmic_regs_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int AW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_start_wr,
    input  logic          bus_wr_byte,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd_req,
    output logic          bus_rd_valid,
    output logic [DW-1:0] bus_rdata,
    output logic          fwd_wr,
    output logic          fwd_rd,
    output logic [AW-1:0] fwd_addr,
    output logic [DW-1:0] fwd_wdata,
    input  logic [DW-1:0] fwd_rdata,
    output logic          dev_off_pulse
);

    logic [AW-1:0]        ptr;
    logic                 wr_fire, rd_fire, rsp_active, soft_clr;
    addr_kind_e           kind;
    logic [CFG_IDX_W-1:0] slot;
    logic [DW-1:0]        cfg_q [NUM_CFG];
    logic [DW-1:0]        local_rdata;
    logic                 off_q;

    pmic_txn_fsm #(.AW(AW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_start   (bus_start_wr),
        .ev_byte    (bus_wr_byte),
        .ev_rd      (bus_rd_req),
        .byte_in    (bus_wdata),
        .soft_clr   (soft_clr),
        .ptr        (ptr),
        .wr_fire    (wr_fire),
        .rd_fire    (rd_fire),
        .rsp_active (rsp_active)
    );

    always_comb begin
        kind     = kind_of(ptr);
        slot     = (kind == AK_CFG) ? slot_of(ptr) : '0;
        soft_clr = wr_fire && (ptr == ADR_OFF) && bus_wdata[0];
        unique case (kind)
            AK_CONST: local_rdata = const_val(ptr);
            AK_CFG:   local_rdata = rd_view(ptr, cfg_q[slot]);
            default:  local_rdata = '0;
        endcase
    end

    pmic_cfg_bank #(.DW(DW), .NUM(NUM_CFG), .IW(CFG_IDX_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .wr_en    (wr_fire && kind == AK_CFG),
        .wr_slot  (slot),
        .wr_data  (bus_wdata),
        .cfg_q    (cfg_q)
    );

    pmic_resp_path #(.DW(DW), .AW(AW)) u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_fire     (wr_fire),
        .rd_fire     (rd_fire),
        .target_fwd  (kind == AK_FWD),
        .ptr         (ptr),
        .wdata       (bus_wdata),
        .local_rdata (local_rdata),
        .fwd_rdata   (fwd_rdata),
        .rsp_active  (rsp_active),
        .fwd_wr      (fwd_wr),
        .fwd_rd      (fwd_rd),
        .fwd_addr    (fwd_addr),
        .fwd_wdata   (fwd_wdata),
        .rsp_data    (bus_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) off_q <= 1'b0;
        else        off_q <= soft_clr;
    end

    assign dev_off_pulse = off_q;
    assign bus_rd_valid  = rsp_active;

    // R7: device-off request is announced the cycle after the byte
    a_r7_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> dev_off_pulse);

    // R11: sibling writes only target the forwarded windows
    a_r11_fwd_window: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_wr |-> kind_of(fwd_addr) == AK_FWD);

    // R3: valid data always follows an accepted read
    a_r3_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_valid |-> $past(bus_rd_req));

endmodule

// File: tb/sim_pmic_regslave.sv
module sim_pmic_regslave;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_start_wr = 1'b0, bus_wr_byte = 1'b0, bus_rd_req = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_rd_valid, fwd_wr, fwd_rd, dev_off_pulse;
    logic [7:0] bus_rdata, fwd_addr, fwd_wdata, fwd_rdata;

    always #5 clk = ~clk;

    pmic_regslave u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_start_wr(bus_start_wr), .bus_wr_byte(bus_wr_byte), .bus_wdata(bus_wdata),
        .bus_rd_req(bus_rd_req), .bus_rd_valid(bus_rd_valid), .bus_rdata(bus_rdata),
        .fwd_wr(fwd_wr), .fwd_rd(fwd_rd), .fwd_addr(fwd_addr), .fwd_wdata(fwd_wdata),
        .fwd_rdata(fwd_rdata), .dev_off_pulse(dev_off_pulse)
    );

    // sibling register model
    logic [7:0] sib_mem [256];
    assign fwd_rdata = fwd_rd ? sib_mem[fwd_addr] : 8'h00;
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) sib_mem[i] <= 8'h00;
        end else if (fwd_wr) begin
            sib_mem[fwd_addr] <= fwd_wdata;
        end
    end

    int         n_chk = 0, n_fail = 0;
    logic [7:0] exp_loc [256];
    logic [7:0] exp_sib [256];
    logic [7:0] ptr_m = 8'h00;
    int         mode_m = 0;   // 0 none, 1 expect pointer, 2 writing

    function automatic bit is_fwd(input logic [7:0] a);
        return (a >= 8'h17 && a <= 8'h1C) || (a >= 8'h21 && a <= 8'h31);
    endfunction

    function automatic bit is_held(input logic [7:0] a);
        return (a >= 8'h02 && a <= 8'h13) || a == 8'h15 || a == 8'h16 ||
               a == 8'h20 || (a >= 8'h32 && a <= 8'h38) || a == 8'h3A;
    endfunction

    function automatic logic [7:0] rv(input logic [7:0] a);
        case (a)
            8'h02: rv = 8'h0C; 8'h03: rv = 8'h05; 8'h04: rv = 8'h02;
            8'h05: rv = 8'h0C; 8'h06: rv = 8'h03; 8'h07: rv = 8'h33;
            8'h08: rv = 8'h03; 8'h0A: rv = 8'h95; 8'h0B: rv = 8'h7E;
            8'h0E: rv = 8'h03; 8'h15: rv = 8'h01; 8'h16: rv = 8'h09;
            8'h36: rv = 8'h03; 8'h37: rv = 8'hC0; 8'h3A: rv = 8'h05;
            default: rv = 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] vclamp(input logic [7:0] v);
        return ((v & 8'h1F) > 8'h12) ? 8'h12 : (v & 8'h1F);
    endfunction

    function automatic logic [7:0] shaped(input logic [7:0] a, input logic [7:0] v);
        if (a == 8'h02) return (v & 8'h0E) | vclamp(v);
        if (a == 8'h04 || a == 8'h05) return vclamp(v);
        if (a == 8'h20) return 8'h0D;
        if (a == 8'h06 || (a >= 8'h0C && a <= 8'h11)) return v & 8'h03;
        if (a == 8'h07 || a == 8'h3A) return v & 8'h3F;
        if (a == 8'h08 || a == 8'h09 || a == 8'h15) return v & 8'h07;
        if (a == 8'h0B || a == 8'h16 || a == 8'h36) return v & 8'h7F;
        if (a == 8'h33 || a == 8'h35) return v & 8'h1F;
        if (a == 8'h38) return v & 8'h0F;
        return v;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        if (a == 8'h01) return 8'h22;
        if (a == 8'h15) return exp_loc[a] | 8'h80;
        if (is_held(a)) return exp_loc[a];
        if (is_fwd(a))  return exp_sib[a];
        return 8'h00;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 256; i++) exp_loc[i] = rv(8'(i));
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic ev_start();
        bus_start_wr = 1'b1;
        @(negedge clk);
        bus_start_wr = 1'b0;
        mode_m = 1;
    endtask

    task automatic ev_byte(input logic [7:0] v);
        bus_wr_byte = 1'b1;
        bus_wdata   = v;
        @(negedge clk);
        bus_wr_byte = 1'b0;
        if (mode_m == 1) begin
            ptr_m  = v;
            mode_m = 2;
        end else if (mode_m == 2) begin
            if (ptr_m == 8'h14 && v[0]) begin
                model_reset();
                ptr_m = 8'h00;
            end else begin
                if (is_held(ptr_m)) exp_loc[ptr_m] = shaped(ptr_m, v);
                else if (is_fwd(ptr_m)) exp_sib[ptr_m] = v;
                ptr_m = ptr_m + 8'd1;
            end
        end
    endtask

    task automatic rd_burst(input int n, input string tag);
        logic [7:0] e;
        bus_rd_req = 1'b1;
        for (int i = 0; i < n; i++) begin
            e = exp_rd(ptr_m);
            ptr_m = ptr_m + 8'd1;
            @(negedge clk);
            if (i == n - 1) bus_rd_req = 1'b0;
            chk({tag, " valid"}, {7'd0, bus_rd_valid}, 8'h01);
            chk(tag, bus_rdata, e);
        end
        mode_m = 0;
    endtask

    task automatic wr_seq(input logic [7:0] a, input logic [7:0] v);
        ev_start();
        ev_byte(a);
        ev_byte(v);
    endtask

    task automatic rd_at(input logic [7:0] a, input int n, input string tag);
        ev_start();
        ev_byte(a);
        rd_burst(n, tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        model_reset();
        for (int i = 0; i < 256; i++) exp_sib[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: quiet outputs and reset contents across the whole map
        chk("R10 rd_valid idle", {7'd0, bus_rd_valid}, 8'h00);
        chk("R10 fwd_wr idle", {7'd0, fwd_wr}, 8'h00);
        chk("R10 dev_off idle", {7'd0, dev_off_pulse}, 8'h00);
        rd_at(8'h00, 64, "R10 reset sweep");

        // R4: revision is read-only
        wr_seq(8'h01, 8'h55);
        rd_at(8'h01, 1, "R4 revision");

        // R5: clamps
        wr_seq(8'h02, 8'h1F); rd_at(8'h02, 1, "R5 vc1 1F");
        wr_seq(8'h02, 8'hF3); rd_at(8'h02, 1, "R5 vc1 F3");
        wr_seq(8'h02, 8'h05); rd_at(8'h02, 1, "R5 vc1 05");
        wr_seq(8'h04, 8'h15); rd_at(8'h04, 1, "R5 vc3 15");
        wr_seq(8'h05, 8'h11); rd_at(8'h05, 1, "R5 vc4 11");

        // R6: masks, one burst over the whole held window
        ev_start(); ev_byte(8'h06);
        for (int i = 0; i < 14; i++) ev_byte(8'hFF);
        rd_at(8'h06, 14, "R6 masks");
        wr_seq(8'h3A, 8'hFF); rd_at(8'h3A, 1, "R6 debounce");

        // R8: oscillator view
        wr_seq(8'h15, 8'hFE); rd_at(8'h15, 1, "R8 osc");

        // R9: constant register
        wr_seq(8'h20, 8'hF0); rd_at(8'h20, 1, "R9 bbsms");

        // R12: unmapped write ignored, pointer still moves
        wr_seq(8'h1D, 8'hAA); rd_at(8'h1C, 5, "R12 unmapped");

        // R2: wrap of the pointer during a write burst
        ev_start(); ev_byte(8'hFF);
        ev_byte(8'h11); ev_byte(8'h22); ev_byte(8'h33); ev_byte(8'h44);
        rd_at(8'h02, 1, "R2 wrap");

        // R11: forwarded write strobe timing
        ev_start(); ev_byte(8'h21);
        bus_wr_byte = 1'b1; bus_wdata = 8'h5A;
        @(negedge clk);
        bus_wr_byte = 1'b0;
        chk("R11 fwd_wr", {7'd0, fwd_wr}, 8'h01);
        chk("R11 fwd_addr", fwd_addr, 8'h21);
        chk("R11 fwd_wdata", fwd_wdata, 8'h5A);
        exp_sib[8'h21] = 8'h5A; ptr_m = 8'h22;
        ev_start(); ev_byte(8'h17);
        for (int i = 0; i < 6; i++) ev_byte(8'(8'hA0 + i));
        rd_at(8'h16, 8, "R11 fwd readback");

        // R1: a byte after a read is ignored
        rd_at(8'h03, 1, "R1 pre");
        mode_m = 0;
        ev_byte(8'h99);
        rd_burst(1, "R1 stray byte");

        // R7: bit 0 clear has no effect
        wr_seq(8'h0A, 8'h11);
        wr_seq(8'h14, 8'hFE);
        rd_at(8'h0A, 1, "R7 no-op");
        // R7: device-off in the middle of a burst
        ev_start(); ev_byte(8'h13); ev_byte(8'h6C);
        bus_wr_byte = 1'b1; bus_wdata = 8'h01;
        @(negedge clk);
        bus_wr_byte = 1'b0;
        chk("R7 pulse", {7'd0, dev_off_pulse}, 8'h01);
        model_reset(); ptr_m = 8'h00;
        ev_byte(8'h77); ev_byte(8'h66);
        ev_byte(8'h1B);
        rd_at(8'h00, 24, "R7 after reset");

        // R3 and R11: random traffic
        for (int it = 0; it < 400; it++) begin
            logic [7:0] a;
            int         n;
            a = 8'($urandom_range(0, 8'h3F));
            n = $urandom_range(1, 4);
            ev_start();
            ev_byte(a);
            for (int k = 0; k < n; k++) ev_byte(8'($urandom()));
            rd_at(a, n + 1, "R3 random");
        end

        summary();
        $finish;
    end

endmodule